// File: doc/BRIEF.md
# Video Memory Read-Ahead Unit

This unit serves the host read side of a video display processor that holds three memories. The first is a byte-organised video RAM. The second is a narrow colour palette RAM and the third a small vertical-scroll RAM. The host programs an access code and a 16-bit address with a control command. If the code names a read, the unit uses memory access slots to fetch the next word into a read-ahead register before the host asks for it. Once that word is complete it advances the address by the auto-increment value. A later host word read takes the word at once or stalls until the word is ready.

Palette and vertical-scroll words are narrower than the host word. The bits those memories do not hold are filled from the value in the write FIFO slot that the write pointer currently selects. A byte-wide legacy read port also returns the read-ahead register. That port discards any fetch in progress and switches the unit to byte video-RAM reads.

The controller has three states. `ST_IDLE` means nothing is held. `ST_LOWBYTE` means the upper byte of a video-RAM word is held and the lower byte is still owed. `ST_HELD` means a complete word waits for the host. The transitions are:
- `fetch_hi`: IDLE to LOWBYTE, the first video-RAM byte.
- `fetch_one`: IDLE to HELD, a palette, scroll or byte fetch.
- `fetch_lo`: LOWBYTE to HELD, the second video-RAM byte.
- `consume`: HELD to IDLE, on a host word read.
- `flush`: any state to IDLE, on a control command load or a host byte read.

Top module: `vram_prefetch_unit`

## Requirements
- R1: After reset the state is ST_IDLE. The access code is 6'h01, a write, so no fetch starts. The address is 0, the read-ahead word is 0 and host_rd_ready is low.
- R2: Access code low nibble 4'h0 (video-RAM word read) needs two granted slots. The first reads the byte at address with bit 0 cleared into bits 15:8 and leaves bits 7:0 zero. The second ORs in the byte at address with bit 0 set. host_rd_ready cannot rise between the two fetches.
- R3: The address advances by auto_inc (8 bits, zero-extended), modulo 2^16, in the cycle the word completes. It does not advance on the first byte of a video-RAM word or on the host read.
- R4: Code nibble 4'h8 (palette read) selects mem_sel 2'd1. The index is (address>>1) mod PAL_DEPTH. The result is (mem_rdata & PAL_MASK) | (fifo_slot_val & ~PAL_MASK).
- R5: Code nibble 4'h4 (scroll read) selects mem_sel 2'd2. The index is (address>>1) & 63, replaced by 0 when it is PAL-independent and at or above VS_DEPTH. Bits outside VS_MASK come from fifo_slot_val.
- R6: Code nibble 4'hC (byte video-RAM read) fetches the byte at address with bit 0 inverted into bits 7:0. Bits 15:8 come from fifo_slot_val[15:8]. The word completes in one slot.
- R7: No fetch (mem_en low) occurs while code bit 0 is set, while the first half of a control command is pending, or for any other code nibble.
- R8: host_rd_ready is high exactly when host_rd_word is high in ST_HELD. That cycle consumes the word, and no new fetch starts before it. host_rd_data holds its value in ST_HELD.
- R9: A host_rd_byte pulse clears the fetched, read-pending and control-pending flags. It sets the code to 6'h0C and discards a half-fetched video-RAM word. host_rd_data shows the read-ahead register.
- R10: cmd_load loads the code and address and clears every flag. It takes priority over a byte read, a first-half mark and a fetch in the same cycle. A host_rd_byte likewise blocks a fetch in its cycle.
- R11: mem_en is high only in a cycle with mem_slot high, and then mem_sel/mem_addr name the memory and index of R2, R4, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Second half of control command: load code and address |
| cmd_code | input | 6 | Access code to load |
| cmd_addr | input | 16 | Address to load |
| ctl_first | input | 1 | First half of a control command has arrived |
| auto_inc | input | 8 | Auto-increment step |
| fifo_slot_val | input | 16 | Value in the write FIFO slot at the write pointer |
| mem_slot | input | 1 | Single-cycle memory access slot grant |
| mem_en | output | 1 | Memory read performed this cycle |
| mem_sel | output | 2 | Memory select: 0 video RAM, 1 palette, 2 scroll |
| mem_addr | output | 16 | Byte address or word index |
| mem_rdata | input | 16 | Combinational read data (video-RAM byte in bits 7:0) |
| host_rd_word | input | 1 | Host word read request |
| host_rd_byte | input | 1 | Host byte read strobe |
| host_rd_ready | output | 1 | Word read completes this cycle |
| host_rd_data | output | 16 | Read-ahead word |

## Verification
Random streams mix all five code nibbles with write codes, sparse slot grants and stray first-half marks. This separates correct slot gating from fetching too eagerly or too lazily. Word reads that arrive early stall, and those that arrive late find a held word. Together they show that the address moves at fetch completion rather than at the host read. Directed cases hit specific corners, each checked against a bench model: scroll indices past the memory size, palette index wrap and 16-bit address wrap. They also cover a control load during a word's second byte and a byte read during the same.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LOWBYTE, ST_HELD} vpf_state_e;
    typedef enum logic [2:0] {K_NONE, K_VWORD, K_VBYTE, K_PAL, K_VSCR} vpf_kind_e;

    localparam logic [1:0] SEL_VRAM = 2'd0;
    localparam logic [1:0] SEL_PAL  = 2'd1;
    localparam logic [1:0] SEL_VSCR = 2'd2;
    localparam logic [5:0] CODE_BYTE_RD = 6'h0C;
    localparam logic [5:0] CODE_RESET   = 6'h01;

    function automatic vpf_kind_e code_kind(input logic [5:0] code);
        vpf_kind_e k;
        unique case (code[3:0])
            4'h0:    k = K_VWORD;
            4'hC:    k = K_VBYTE;
            4'h8:    k = K_PAL;
            4'h4:    k = K_VSCR;
            default: k = K_NONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/vpf_access_reg.sv
module vpf_access_reg
    import vpf_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic [CW-1:0] cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic          ctl_first,
    input  logic          byte_rd,
    input  logic          adv,
    input  logic [IW-1:0] inc,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] code,
    output logic          ctl_pend
);
    localparam int PADW = AW - IW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            code     <= CODE_RESET;
            ctl_pend <= 1'b0;
        end else if (cmd_load) begin
            addr     <= cmd_addr;
            code     <= cmd_code;
            ctl_pend <= 1'b0;
        end else if (byte_rd) begin
            code     <= CODE_BYTE_RD;
            ctl_pend <= 1'b0;
        end else begin
            if (ctl_first) ctl_pend <= 1'b1;
            if (adv)       addr <= addr + {{PADW{1'b0}}, inc};
        end
    end

    AST_BYTE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_rd && !cmd_load) |=> (code == CODE_BYTE_RD && !ctl_pend)); // R9

    AST_ADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cmd_load) |=> $stable(addr)); // R3
endmodule

// File: rtl/vpf_seq.sv
module vpf_seq
    import vpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  vpf_kind_e  kind,
    input  logic       code_wr,
    input  logic       ctl_pend,
    input  logic       slot,
    input  logic       cmd_load,
    input  logic       byte_rd,
    input  logic       word_rd,
    output vpf_state_e state,
    output logic       fetch_go,
    output logic       step_hi,
    output logic       step_lo,
    output logic       step_one,
    output logic       adv,
    output logic       ready
);
    vpf_state_e state_nx;
    logic       eligible;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        step_hi  = 1'b0;
        step_lo  = 1'b0;
        step_one = 1'b0;
        ready    = 1'b0;
        eligible = slot && !code_wr && !ctl_pend && !cmd_load && !byte_rd
                   && (kind != K_NONE);
        if (cmd_load || byte_rd) begin
            state_nx = ST_IDLE;                  // flush
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (eligible) begin
                        if (kind == K_VWORD) begin
                            step_hi  = 1'b1;     // fetch_hi
                            state_nx = ST_LOWBYTE;
                        end else begin
                            step_one = 1'b1;     // fetch_one
                            state_nx = ST_HELD;
                        end
                    end
                end
                ST_LOWBYTE: begin
                    if (eligible) begin
                        step_lo  = 1'b1;         // fetch_lo
                        state_nx = ST_HELD;
                    end
                end
                ST_HELD: begin
                    if (word_rd) begin
                        ready    = 1'b1;         // consume
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
        fetch_go = step_hi | step_lo | step_one;
        adv      = step_lo | step_one;
    end

    AST_HI_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_hi |=> (state == ST_LOWBYTE)); // R2

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R8

    AST_GO_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> (slot && !code_wr && !ctl_pend)); // R7

    AST_NO_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |-> !fetch_go); // R8
endmodule

// File: rtl/vpf_datapath.sv
module vpf_datapath
    import vpf_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int          PAL_DEPTH = 64,
    parameter int          VS_DEPTH  = 40,
    parameter logic [15:0] PAL_MASK  = 16'h0EEE,
    parameter logic [15:0] VS_MASK   = 16'h07FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vpf_kind_e     kind,
    input  vpf_state_e    state,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] fifo_val,
    input  logic [DW-1:0] rdata,
    input  logic          step_hi,
    input  logic          step_lo,
    input  logic          step_one,
    output logic [1:0]    mem_sel,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] pf
);
    localparam int PAL_AW = $clog2(PAL_DEPTH);
    localparam int VS_RAW = 6;
    localparam int HB     = DW / 2;

    logic [AW-2:0]     half;
    logic [PAL_AW-1:0] pal_idx;
    logic [VS_RAW-1:0] vs_raw, vs_idx;

    always_comb begin
        half    = addr[AW-1:1];
        pal_idx = half[PAL_AW-1:0];
        vs_raw  = half[VS_RAW-1:0];
        vs_idx  = ({26'd0, vs_raw} >= 32'(VS_DEPTH)) ? '0 : vs_raw;
        mem_sel  = SEL_VRAM;
        mem_addr = addr;
        unique case (kind)
            K_VWORD: mem_addr = (state == ST_LOWBYTE) ? (addr | AW'(1)) : (addr & ~AW'(1));
            K_VBYTE: mem_addr = addr ^ AW'(1);
            K_PAL: begin
                mem_sel  = SEL_PAL;
                mem_addr = {{(AW-PAL_AW){1'b0}}, pal_idx};
            end
            K_VSCR: begin
                mem_sel  = SEL_VSCR;
                mem_addr = {{(AW-VS_RAW){1'b0}}, vs_idx};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf <= '0;
        end else if (step_hi) begin
            pf <= {rdata[HB-1:0], {HB{1'b0}}};
        end else if (step_lo) begin
            pf <= {pf[DW-1:HB], pf[HB-1:0] | rdata[HB-1:0]};
        end else if (step_one) begin
            unique case (kind)
                K_PAL:   pf <= (rdata & PAL_MASK) | (fifo_val & ~PAL_MASK);
                K_VSCR:  pf <= (rdata & VS_MASK) | (fifo_val & ~VS_MASK);
                default: pf <= {fifo_val[DW-1:HB], rdata[HB-1:0]};
            endcase
        end
    end

    AST_VS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_one && mem_sel == SEL_VSCR) |-> (32'(mem_addr) < VS_DEPTH)); // R5

    AST_PAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_one && mem_sel == SEL_PAL) |-> (32'(mem_addr) < PAL_DEPTH)); // R4

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && $past(state) == ST_HELD) |-> $stable(pf)); // R8
endmodule

// File: rtl/vram_prefetch_unit.sv
module vram_prefetch_unit
    import vpf_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int          IW        = 8,
    parameter int          CW        = 6,
    parameter int          PAL_DEPTH = 64,
    parameter int          VS_DEPTH  = 40,
    parameter logic [15:0] PAL_MASK  = 16'h0EEE,
    parameter logic [15:0] VS_MASK   = 16'h07FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic [CW-1:0] cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic          ctl_first,
    input  logic [IW-1:0] auto_inc,
    input  logic [DW-1:0] fifo_slot_val,
    input  logic          mem_slot,
    output logic          mem_en,
    output logic [1:0]    mem_sel,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          host_rd_word,
    input  logic          host_rd_byte,
    output logic          host_rd_ready,
    output logic [DW-1:0] host_rd_data
);
    logic [AW-1:0] addr;
    logic [CW-1:0] code;
    logic          ctl_pend;
    vpf_state_e    state;
    vpf_kind_e     kind;
    logic          step_hi, step_lo, step_one, adv;

    assign kind = code_kind(code);

    vpf_access_reg #(.AW(AW), .IW(IW), .CW(CW)) u_acc (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .ctl_first(ctl_first), .byte_rd(host_rd_byte),
        .adv(adv), .inc(auto_inc), .addr(addr), .code(code), .ctl_pend(ctl_pend)
    );

    vpf_seq u_seq (
        .clk(clk), .rst_n(rst_n), .kind(kind), .code_wr(code[0]),
        .ctl_pend(ctl_pend), .slot(mem_slot), .cmd_load(cmd_load),
        .byte_rd(host_rd_byte), .word_rd(host_rd_word), .state(state),
        .fetch_go(mem_en), .step_hi(step_hi), .step_lo(step_lo),
        .step_one(step_one), .adv(adv), .ready(host_rd_ready)
    );

    vpf_datapath #(.AW(AW), .DW(DW), .PAL_DEPTH(PAL_DEPTH), .VS_DEPTH(VS_DEPTH),
                   .PAL_MASK(PAL_MASK), .VS_MASK(VS_MASK)) u_dp (
        .clk(clk), .rst_n(rst_n), .kind(kind), .state(state), .addr(addr),
        .fifo_val(fifo_slot_val), .rdata(mem_rdata), .step_hi(step_hi),
        .step_lo(step_lo), .step_one(step_one), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .pf(host_rd_data)
    );

    AST_EN_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> mem_slot); // R11

    AST_LOAD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (!host_rd_ready && state == ST_IDLE)); // R10
endmodule

// File: tb/vram_prefetch_unit_bench.sv
`timescale 1ns/1ps
module vram_prefetch_unit_bench;
    localparam int          PAL_DEPTH = 64;
    localparam int          VS_DEPTH  = 40;
    localparam logic [15:0] PAL_MASK  = 16'h0EEE;
    localparam logic [15:0] VS_MASK   = 16'h07FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_load = 0, ctl_first = 0, mem_slot = 0;
    logic        host_rd_word = 0, host_rd_byte = 0;
    logic [5:0]  cmd_code = 0;
    logic [15:0] cmd_addr = 0, fifo_slot_val = 0, mem_rdata;
    logic [7:0]  auto_inc = 8'd2;
    logic        mem_en, host_rd_ready;
    logic [1:0]  mem_sel;
    logic [15:0] mem_addr, host_rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state: 0 idle, 1 low byte owed, 2 held
    int          m_st;
    logic [15:0] m_addr, m_pf;
    logic [5:0]  m_code;
    logic        m_pend;

    always #2.5 clk = ~clk;

    vram_prefetch_unit u_vram_prefetch_unit (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .ctl_first(ctl_first), .auto_inc(auto_inc),
        .fifo_slot_val(fifo_slot_val), .mem_slot(mem_slot), .mem_en(mem_en),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .host_rd_word(host_rd_word), .host_rd_byte(host_rd_byte),
        .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data)
    );

    function automatic logic [7:0] vram_byte(input logic [15:0] a);
        return 8'(a * 37 + 5) ^ a[15:8];
    endfunction
    function automatic logic [15:0] word_at(input logic [15:0] i, input logic [15:0] salt);
        return (i * 16'h1357) ^ salt;
    endfunction

    // memory model: unused bits deliberately non-zero
    always_comb begin
        case (mem_sel)
            2'd0:    mem_rdata = {8'hA5, vram_byte(mem_addr)};
            2'd1:    mem_rdata = word_at(mem_addr, 16'hFFFF);
            default: mem_rdata = word_at(mem_addr, 16'hC3C3);
        endcase
    end

    // 0 none, 1 vram word, 2 vram byte, 3 palette, 4 scroll
    function automatic int kind_of(input logic [5:0] c);
        if (c[0]) return 0;
        case (c[3:0])
            4'h0: return 1;
            4'hC: return 2;
            4'h8: return 3;
            4'h4: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] vs_index(input logic [15:0] a);
        logic [5:0] r = a[6:1];
        return (int'(r) >= VS_DEPTH) ? 16'd0 : {10'd0, r};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic slot, input logic ld, input logic [5:0] lc,
                        input logic [15:0] la, input logic brd, input logic wrd,
                        input logic first, input string tag_in);
        int k;
        logic en, rdy;
        logic [1:0] sel;
        logic [15:0] ea;
        string tag;
        int n_st;
        logic [15:0] n_addr, n_pf;
        logic [5:0] n_code;
        logic n_pend;
        @(negedge clk);
        mem_slot = slot; cmd_load = ld; cmd_code = lc; cmd_addr = la;
        host_rd_byte = brd; host_rd_word = wrd; ctl_first = first;
        fifo_slot_val = 16'($urandom);
        #1;
        k = kind_of(m_code);
        case (k)
            1: tag = "R2"; 2: tag = "R6"; 3: tag = "R4"; 4: tag = "R5";
            default: tag = "R7";
        endcase
        if (tag_in != "") tag = tag_in;
        en = slot && k != 0 && !m_pend && !ld && !brd && m_st != 2;
        rdy = wrd && m_st == 2 && !ld && !brd;
        check({tag, " R11 mem_en"}, 16'(mem_en), 16'(en));
        check("R8 ready", 16'(host_rd_ready), 16'(rdy));
        check("R8 R9 data", host_rd_data, m_pf);
        sel = 2'd0;
        ea = 16'hx;
        n_st = m_st; n_addr = m_addr; n_pf = m_pf; n_code = m_code; n_pend = m_pend;
        if (en) begin
            case (k)
                1: begin
                    ea = (m_st == 1) ? (m_addr | 16'd1) : (m_addr & 16'hFFFE);
                    if (m_st == 0) begin
                        n_pf = {vram_byte(ea), 8'h00}; n_st = 1;
                    end else begin
                        n_pf = m_pf | {8'h00, vram_byte(ea)}; n_st = 2;
                        n_addr = m_addr + {8'd0, auto_inc};
                    end
                end
                2: begin
                    ea = m_addr ^ 16'd1;
                    n_pf = {fifo_slot_val[15:8], vram_byte(ea)};
                end
                3: begin
                    sel = 2'd1; ea = {10'd0, m_addr[6:1]};
                    n_pf = (word_at(ea, 16'hFFFF) & PAL_MASK) | (fifo_slot_val & ~PAL_MASK);
                end
                default: begin
                    sel = 2'd2; ea = vs_index(m_addr);
                    n_pf = (word_at(ea, 16'hC3C3) & VS_MASK) | (fifo_slot_val & ~VS_MASK);
                end
            endcase
            if (k != 1) begin n_st = 2; n_addr = m_addr + {8'd0, auto_inc}; end
            check({tag, " R11 sel"}, 16'(mem_sel), 16'(sel));
            check({tag, " R3 R11 addr"}, mem_addr, ea);
        end
        if (ld) begin
            n_st = 0; n_code = lc; n_addr = la; n_pend = 0;
        end else if (brd) begin
            n_st = 0; n_code = 6'h0C; n_pend = 0;
        end else begin
            if (first) n_pend = 1;
            if (rdy) n_st = 0;
        end
        @(posedge clk);
        m_st = n_st; m_addr = n_addr; m_pf = n_pf; m_code = n_code; m_pend = n_pend;
    endtask

    task automatic load(input logic [5:0] c, input logic [15:0] a);
        tick(0, 1, c, a, 0, 0, 0, "R10");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_st = 0; m_addr = 0; m_pf = 0; m_code = 6'h01; m_pend = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready", 16'(host_rd_ready), 16'd0);
        check("R1 data", host_rd_data, 16'd0);
        rst_n = 1'b1;
        // R1: write code after reset, slot offered, nothing fetched
        tick(1, 0, 0, 0, 0, 1, 0, "R1");
        // R2: vram word split across two slots, ready stalls in between
        auto_inc = 8'd2;
        load(6'h00, 16'h1235);
        tick(1, 0, 0, 0, 0, 1, 0, "R2");
        tick(0, 0, 0, 0, 0, 1, 0, "R2");
        tick(1, 0, 0, 0, 0, 1, 0, "R2");
        tick(0, 0, 0, 0, 0, 1, 0, "R2");
        // R3: wrap at 16 bits, seen via next fetch address
        auto_inc = 8'd3;
        load(6'h0C, 16'hFFFE);
        tick(1, 0, 0, 0, 0, 0, 0, "R6");
        tick(1, 0, 0, 0, 0, 1, 0, "R8");
        tick(1, 0, 0, 0, 0, 0, 0, "R3");
        // R5: scroll index beyond size, and 6-bit wrap
        load(6'h04, 16'h0060);
        tick(1, 0, 0, 0, 0, 1, 0, "R5");
        load(6'h04, 16'h0090);
        tick(1, 0, 0, 0, 0, 1, 0, "R5");
        // R4: palette index wrap
        load(6'h08, 16'h0082);
        tick(1, 0, 0, 0, 0, 1, 0, "R4");
        // R7: pending first half blocks fetch; write code blocks fetch
        load(6'h08, 16'h0010);
        tick(0, 0, 0, 0, 0, 0, 1, "R7");
        tick(1, 0, 0, 0, 0, 0, 0, "R7");
        load(6'h05, 16'h0010);
        tick(1, 0, 0, 0, 0, 0, 0, "R7");
        // R9: byte read mid-word discards half and switches code
        load(6'h00, 16'h4000);
        tick(1, 0, 0, 0, 0, 0, 0, "R2");
        tick(1, 0, 0, 0, 1, 0, 0, "R9");
        tick(1, 0, 0, 0, 0, 0, 0, "R9");
        tick(0, 0, 0, 0, 1, 0, 0, "R9");
        // R10: load during second byte wins
        load(6'h00, 16'h2000);
        tick(1, 0, 0, 0, 0, 0, 0, "R2");
        tick(1, 1, 6'h08, 16'h0004, 1, 0, 1, "R10");
        tick(1, 0, 0, 0, 0, 1, 0, "R10");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic ld, brd;
            logic [5:0] lc;
            int pick;
            ld = ($urandom % 100) < 3;
            brd = ($urandom % 100) < 2;
            pick = $urandom % 7;
            case (pick)
                0: lc = 6'h00; 1: lc = 6'h0C; 2: lc = 6'h08; 3: lc = 6'h04;
                4: lc = 6'h01; 5: lc = 6'h02; default: lc = 6'h05;
            endcase
            lc[5:4] = 2'($urandom);
            if (ld) auto_inc = 8'($urandom);
            tick(($urandom % 2) == 0, ld, lc, 16'($urandom), brd,
                 ($urandom % 10) < 3, ($urandom % 100) < 3, "");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule